// File: doc/BRIEF.md
# Bus Arbitration Lock Watchdog

This block lets several software clients share one serial-interface master without stepping on each other. A client takes the interface by setting a lock bit with an atomic read-modify-write on the control word. It owns the interface until it clears that bit. An ownership key counts every release, so another client can tell that ownership changed between two of its reads.

While the lock is held, a timer advances on a 1 ms tick input. If the holder does not release the lock within the programmed number of ticks, the watchdog evicts it. It drops the lock, advances the key, raises a sticky error flag and restores the default timeout. The block sits on a plain 32-bit register bus with two word addresses. It has a single-cycle write strobe and a read path that is decoded without a register.

Top module: `arb_lock_wdog`

## Requirements
- R1: After reset the control word (address 0) reads 0 and the timeout word (address 1) reads the default timeout DEF_TMO, which is 250 unless overridden.
- R2: The control word carries the key in bits 31..2 (zero-extended from KEY_W bits), the lock bit in bit 1 and the error flag in bit 0. The timeout word carries the timeout in bits TMO_W-1..0 (20 by default) with zeros above. Writes cannot alter the key field.
- R3: Writing the control word with bit 1 = 1 while the lock is low sets the lock after that clock edge and starts the timer from zero.
- R4: Writing the control word with bit 1 = 1 while the lock is already high leaves the lock and the key unchanged.
- R5: Writing the control word with bit 1 = 0 while the lock is high clears the lock and increments the key by one.
- R6: The timer advances only on clock edges where the tick input is high and the lock is held. Ticks while the lock is low have no effect.
- R7: On the N-th tick counted while the lock is held, where N is the timeout value (or on the first tick when N = 0), the lock clears, the key increments, the error flag sets and the timeout word reloads DEF_TMO.
- R8: A write to the timeout word loads bits TMO_W-1..0 and restarts the running count from zero.
- R9: The error flag is cleared by writing the control word with bit 0 = 1. Writing bit 0 = 0 leaves it unchanged.
- R10: The key counts modulo 2^KEY_W and wraps to zero.
- R11: Expiry takes priority over any write in the same cycle. A release written together with the expiring tick increments the key only once, and the default timeout is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 1 | Word address: 0 control, 1 timeout |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| lock_o | output | 1 | Lock currently held |
| tmo_err_o | output | 1 | Sticky timeout error flag |

## Verification
The bench builds the block with DEF_TMO = 5 and KEY_W = 3, and leaves TMO_W at 20. A default-timeout eviction then takes five ticks instead of 250. The key wraps after eight releases, so R7 and R10 are exercised in a few hundred cycles. Programmed timeouts of 4, 1 and 0 cover the restart path, expiry colliding with a release write, and the zero-timeout case.

// File: rtl/arb_lock_pkg.sv
package arb_lock_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_TMO  = 1'b1;
  localparam int   CTRL_LOCK_BIT = 1;
  localparam int   CTRL_ERR_BIT  = 0;
  localparam int   KEY_FIELD_W   = 30;

  typedef struct packed {
    logic        wr;
    logic        addr;
    logic [31:0] data;
  } bus_wr_t;
endpackage

// File: rtl/arb_lock_core.sv
module arb_lock_core #(
  parameter int KEY_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             lock_bit_i,
  input  logic             err_clr_i,
  input  logic             expire_i,
  output logic             lock_o,
  output logic [KEY_W-1:0] key_o,
  output logic             err_o
);
  logic lock_q, err_q;
  logic [KEY_W-1:0] key_q;
  logic release_w, acquire_w, drop_w;

  assign release_w = ctrl_wr_i && !lock_bit_i && lock_q;
  assign acquire_w = ctrl_wr_i && lock_bit_i && !lock_q;
  assign drop_w    = lock_q && (expire_i || release_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      key_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (drop_w)         lock_q <= 1'b0;
      else if (acquire_w) lock_q <= 1'b1;
      if (drop_w) key_q <= key_q + 1'b1;
      // expiry wins over a same-cycle clear
      if (expire_i)                    err_q <= 1'b1;
      else if (ctrl_wr_i && err_clr_i) err_q <= 1'b0;
    end
  end

  assign lock_o = lock_q;
  assign key_o  = key_q;
  assign err_o  = err_q;
endmodule

// File: rtl/arb_lock_timer.sv
module arb_lock_timer #(
  parameter int TMO_W   = 20,
  parameter int DEF_TMO = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             tick_i,
  input  logic             tmo_wr_i,
  input  logic [TMO_W-1:0] tmo_wdata_i,
  output logic [TMO_W-1:0] tmo_o,
  output logic [TMO_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [TMO_W-1:0] TMO_RST = TMO_W'(DEF_TMO);

  logic [TMO_W-1:0] tmo_q, cnt_q;
  logic [TMO_W:0]   elapsed;
  logic             expire;

  assign elapsed = {1'b0, cnt_q} + 1'b1;
  assign expire  = lock_i && tick_i && (elapsed >= {1'b0, tmo_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q <= TMO_RST;
      cnt_q <= '0;
    end else begin
      if (expire)        tmo_q <= TMO_RST;
      else if (tmo_wr_i) tmo_q <= tmo_wdata_i;
      if (!lock_i || expire || tmo_wr_i) cnt_q <= '0;
      else if (tick_i)                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tmo_o    = tmo_q;
  assign cnt_o    = cnt_q;
  assign expire_o = expire;
endmodule

// File: rtl/arb_lock_rdmux.sv
module arb_lock_rdmux
  import arb_lock_pkg::*;
#(
  parameter int KEY_W = 30,
  parameter int TMO_W = 20
) (
  input  logic             addr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             lock_i,
  input  logic             err_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic [31:0]      rdata_o
);
  logic [KEY_FIELD_W-1:0] key_ext;
  logic [31:0]            tmo_ext;

  always_comb begin
    key_ext = '0;
    key_ext[KEY_W-1:0] = key_i;
    tmo_ext = '0;
    tmo_ext[TMO_W-1:0] = tmo_i;
  end

  always_comb begin
    if (addr_i == ADDR_TMO) rdata_o = tmo_ext;
    else                    rdata_o = {key_ext, lock_i, err_i};
  end
endmodule

// File: rtl/arb_lock_wdog.sv
module arb_lock_wdog
  import arb_lock_pkg::*;
#(
  parameter int KEY_W   = 30,
  parameter int TMO_W   = 20,
  parameter int DEF_TMO = 250
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        tick_ms_i,
  output logic        lock_o,
  output logic        tmo_err_o
);
  bus_wr_t          bus;
  logic             ctrl_wr, tmo_wr, expire;
  logic             lock_q, err_q;
  logic [KEY_W-1:0] key_q;
  logic [TMO_W-1:0] tmo_q, cnt_q;
  logic             unused_wdata;

  assign bus     = '{wr: wr_en_i, addr: addr_i, data: wdata_i};
  assign ctrl_wr = bus.wr && (bus.addr == ADDR_CTRL);
  assign tmo_wr  = bus.wr && (bus.addr == ADDR_TMO);
  assign unused_wdata = ^wdata_i;

  arb_lock_core #(.KEY_W(KEY_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (ctrl_wr),
    .lock_bit_i (bus.data[CTRL_LOCK_BIT]),
    .err_clr_i  (bus.data[CTRL_ERR_BIT]),
    .expire_i   (expire),
    .lock_o     (lock_q),
    .key_o      (key_q),
    .err_o      (err_q)
  );

  arb_lock_timer #(.TMO_W(TMO_W), .DEF_TMO(DEF_TMO)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_i      (lock_q),
    .tick_i      (tick_ms_i),
    .tmo_wr_i    (tmo_wr),
    .tmo_wdata_i (bus.data[TMO_W-1:0]),
    .tmo_o       (tmo_q),
    .cnt_o       (cnt_q),
    .expire_o    (expire)
  );

  arb_lock_rdmux #(.KEY_W(KEY_W), .TMO_W(TMO_W)) u_rdmux (
    .addr_i  (bus.addr),
    .key_i   (key_q),
    .lock_i  (lock_q),
    .err_i   (err_q),
    .tmo_i   (tmo_q),
    .rdata_o (rdata_o)
  );

  assign lock_o    = lock_q;
  assign tmo_err_o = err_q;
endmodule

// File: rtl/arb_lock_wdog_chk.sv
module arb_lock_wdog_chk #(
  parameter int KEY_W   = 30,
  parameter int TMO_W   = 20,
  parameter int DEF_TMO = 250
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lock,
  input logic [KEY_W-1:0] key,
  input logic             err,
  input logic [TMO_W-1:0] tmo,
  input logic [TMO_W-1:0] cnt,
  input logic             tick,
  input logic             tmo_wr
);
  assert_key_on_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock) |-> key == KEY_W'($past(key) + 1'b1));

  assert_key_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(lock) |-> $stable(key));

  assert_err_on_expiry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err) |-> $fell(lock) && tmo == TMO_W'(DEF_TMO));

  assert_cnt_below_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |-> (cnt < tmo) || (cnt == '0));

  assert_cnt_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock && $past(!lock) |-> cnt == '0);

  assert_cnt_no_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock && !tick && !tmo_wr |=> $stable(cnt));

  assert_restart_on_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_wr |=> cnt == '0);
endmodule

bind arb_lock_wdog arb_lock_wdog_chk #(
  .KEY_W(KEY_W), .TMO_W(TMO_W), .DEF_TMO(DEF_TMO)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .lock   (lock_q),
  .key    (key_q),
  .err    (err_q),
  .tmo    (tmo_q),
  .cnt    (cnt_q),
  .tick   (tick_ms_i),
  .tmo_wr (tmo_wr)
);

// File: tb/arb_lock_wdog_tb_top.sv
module arb_lock_wdog_tb_top;
  localparam int KEY_W   = 3;
  localparam int TMO_W   = 20;
  localparam int DEF_TMO = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        addr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        tick_ms_i = 1'b0;
  logic [31:0] rdata_o;
  logic        lock_o, tmo_err_o;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #10 clk_i = ~clk_i;

  arb_lock_wdog #(.KEY_W(KEY_W), .TMO_W(TMO_W), .DEF_TMO(DEF_TMO)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_ms_i(tick_ms_i),
    .lock_o(lock_o), .tmo_err_o(tmo_err_o)
  );

  // behavioural reference model
  bit m_lock, m_err;
  int m_key, m_tmo, m_cnt;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lock = 0; m_err = 0; m_key = 0; m_tmo = DEF_TMO; m_cnt = 0;
    end else if (m_lock && tick_ms_i && (m_cnt + 1 >= m_tmo)) begin
      m_lock = 0; m_key = (m_key + 1) % (1 << KEY_W);
      m_err = 1; m_tmo = DEF_TMO; m_cnt = 0;
    end else begin
      bit nl;
      int nc;
      nl = m_lock;
      nc = m_cnt;
      if (m_lock && tick_ms_i) nc = nc + 1;
      if (wr_en_i && addr_i) begin
        m_tmo = int'(wdata_i[TMO_W-1:0]);
        nc = 0;
      end
      if (wr_en_i && !addr_i) begin
        if (wdata_i[0]) m_err = 0;
        if (wdata_i[1] && !m_lock) nl = 1;
        else if (!wdata_i[1] && m_lock) begin
          nl = 0;
          m_key = (m_key + 1) % (1 << KEY_W);
        end
      end
      if (!m_lock) nc = 0;
      m_lock = nl;
      m_cnt = nc;
    end
  end

  function automatic logic [31:0] model_rd(input logic a);
    if (a) return 32'(m_tmo);
    return (32'(m_key) << 2) | (32'(m_lock) << 1) | 32'(m_err);
  endfunction

  // per-cycle comparison, inputs change only after this point
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      total++;
      if (rdata_o !== model_rd(addr_i) || lock_o !== m_lock || tmo_err_o !== m_err) begin
        bad++;
        $display("FAIL %s cycle compare: rdata=%h lock=%b err=%b expected rdata=%h lock=%b err=%b",
                 cur_req, rdata_o, lock_o, tmo_err_o, model_rd(addr_i), m_lock, m_err);
      end
    end
  end

  task automatic op(input logic w, input logic a, input logic [31:0] d, input logic t);
    @(negedge clk_i); #1;
    wr_en_i = w; addr_i = a; wdata_i = d; tick_ms_i = t;
    @(negedge clk_i); #1;
    wr_en_i = 1'b0; tick_ms_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic a, input logic [31:0] exp);
    #1 addr_i = a;
    #2;
    total++;
    if (rdata_o !== exp) begin
      bad++;
      $display("FAIL %s read addr %0d: got %h expected %h", req, a, rdata_o, exp);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cur_req = "R1";
    rd_chk("R1", 1'b0, 32'h0);
    rd_chk("R1", 1'b1, 32'd5);
    rd_chk("R2", 1'b1, 32'd5);

    cur_req = "R3";
    op(1, 0, 32'h2, 0);
    rd_chk("R3", 1'b0, 32'h2);

    cur_req = "R4";
    op(1, 0, 32'h2, 0);
    rd_chk("R4", 1'b0, 32'h2);
    op(1, 0, 32'hFFFF_FFF6, 0);
    rd_chk("R2", 1'b0, 32'h2);

    cur_req = "R6";
    op(0, 0, 32'h0, 0);
    op(0, 0, 32'h0, 0);
    for (int i = 0; i < 4; i++) op(0, 0, 32'h0, 1);
    rd_chk("R6", 1'b0, 32'h2);

    cur_req = "R8";
    op(1, 1, 32'hFFF0_0004, 0);
    rd_chk("R8", 1'b1, 32'd4);
    for (int i = 0; i < 3; i++) op(0, 0, 32'h0, 1);
    rd_chk("R8", 1'b0, 32'h2);

    cur_req = "R7";
    op(0, 0, 32'h0, 1);
    rd_chk("R7", 1'b0, 32'h5);
    rd_chk("R7", 1'b1, 32'd5);

    cur_req = "R9";
    op(1, 0, 32'h0, 0);
    rd_chk("R9", 1'b0, 32'h5);
    op(1, 0, 32'h1, 0);
    rd_chk("R9", 1'b0, 32'h4);

    cur_req = "R5";
    op(1, 0, 32'h2, 0);
    rd_chk("R5", 1'b0, 32'h6);
    op(1, 0, 32'h0, 0);
    rd_chk("R5", 1'b0, 32'h8);

    cur_req = "R6";
    for (int i = 0; i < 6; i++) op(0, 0, 32'h0, 1);
    rd_chk("R6", 1'b0, 32'h8);

    cur_req = "R10";
    for (int i = 0; i < 6; i++) begin
      op(1, 0, 32'h2, 0);
      op(1, 0, 32'h0, 0);
    end
    rd_chk("R10", 1'b0, 32'h0);

    cur_req = "R11";
    op(1, 0, 32'h2, 0);
    op(1, 1, 32'h1, 0);
    rd_chk("R11", 1'b1, 32'd1);
    op(1, 0, 32'h0, 1);
    rd_chk("R11", 1'b0, 32'h5);
    rd_chk("R11", 1'b1, 32'd5);
    op(1, 0, 32'h1, 0);
    rd_chk("R9", 1'b0, 32'h4);

    cur_req = "R7";
    op(1, 1, 32'h0, 0);
    rd_chk("R7", 1'b1, 32'd0);
    op(1, 0, 32'h2, 0);
    rd_chk("R3", 1'b0, 32'h6);
    op(0, 0, 32'h0, 1);
    rd_chk("R7", 1'b0, 32'h9);
    rd_chk("R7", 1'b1, 32'd5);

    @(negedge clk_i);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule